// File: doc/BRIEF.md
# Static Memory Bank Timing Sequencer

This block runs one access at a time to a single external static memory bank. A host raises `req` with the direction, the access size, a byte address and write data. The block then steps through a fixed order of bus phases: address setup, chip-select setup, strobe, chip-select hold and address hold. It ends with a one-clock acknowledge. The configuration inputs set the length of each phase, and a phase of length zero is skipped. A read captures the memory data on the last clock of its strobe.

After a read, the block can keep the bus quiet for a programmable number of idle clocks so that the memory's output drivers can float off the bus. A request that arrives during that gap waits until the gap is over. Writes never start a gap.

The bus can be 8 or 16 bits wide. A 16-bit bus can carry one 16-bit device or two 8-bit devices. In the two-device case each byte lane has its own write strobe. The configuration inputs must stay stable while an access is in progress.

Top module: `smc_bank_timer`

## Requirements
- R1: While reset is active and afterwards until the first request, `mem_cs_n`, `mem_rd_n` and both bits of `mem_we_n` are high, and `ack`, `mem_addr_vld` and `mem_doe` are low.
- R2: `mem_addr_vld` rises `cfg_addr_gap` clocks (0 to 3) before `mem_cs_n` falls and stays high `cfg_addr_gap` clocks after `mem_cs_n` rises. `mem_cs_n` is never low while `mem_addr_vld` is low.
- R3: For writes and for normal reads, `mem_cs_n` is low for `cfg_cs_setup` clocks (0 to 3) before the strobe starts. No strobe is ever active while `mem_cs_n` is high.
- R4: The strobe lasts `cfg_wait + 1` clocks when `cfg_wait_en` is 1, and exactly one clock when it is 0, whatever value `cfg_wait` holds.
- R5: `mem_cs_n` stays low for `cfg_cs_hold` clocks (0 to 3) after the strobe ends.
- R6: When `cfg_early_rd` is 1, a read drives `mem_rd_n` low in the same clock that `mem_cs_n` falls. It then stays low through the chip-select setup and strobe phases, for `cfg_cs_setup` plus the strobe length. Writes are not affected.
- R7: `ack` is a single-clock pulse in the clock after the address hold phase ends. The host holds `req` high until `ack`, and the next request is accepted in the clock after `ack` at the earliest.
- R8: `rd_data` takes the value of `mem_din` seen in the last clock of the read strobe. On a 16-bit bus, a 16-bit read returns all 16 bits. An 8-bit read returns the byte on lane `req_addr[0]` (0 = bits 7:0, 1 = bits 15:8), zero-extended.
- R9: During the write strobe, `mem_doe` is high and `mem_addr` equals `req_addr`. `mem_dout` carries `req_wdata` for a 16-bit write on a 16-bit bus; otherwise it carries `req_wdata[7:0]` on both lanes. `mem_we_n` bit n is the strobe for lane n.
- R10: When `req` is already pending at `ack`, `mem_addr_vld` of the next access rises `cfg_float + 2` clocks after the `ack` clock if the finished access was a read, and 2 clocks after it if it was a write.
- R11: With `cfg_bus16` = 0, `req_wide` is ignored and every access is an 8-bit access. A write drives `mem_we_n` = 2'b10 and a read returns `mem_din[7:0]` zero-extended. With `cfg_bus16` = 1 and `cfg_dual8` = 0, both strobe bits move together. With `cfg_dual8` = 1, an 8-bit write pulls low only the bit of its lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr_gap | input | 2 | Address setup and hold clocks around chip select |
| cfg_cs_setup | input | 2 | Chip-select clocks before the strobe |
| cfg_cs_hold | input | 2 | Chip-select clocks after the strobe |
| cfg_wait_en | input | 1 | Enables the wait-state count |
| cfg_wait | input | NWS_W | Wait states; strobe is this plus one when enabled |
| cfg_float | input | TDF_W | Idle clocks after a read |
| cfg_early_rd | input | 1 | Read strobe starts with chip select |
| cfg_bus16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_dual8 | input | 1 | 16-bit bus built from two byte-wide devices |
| req | input | 1 | Access request, held until ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 16 | Write data |
| ack | output | 1 | Access complete pulse |
| rd_data | output | 16 | Captured read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_addr_vld | output | 1 | Address valid window |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 2 | Per-lane write strobes, active low |
| mem_dout | output | 16 | Write data to memory |
| mem_doe | output | 1 | Write data drive enable |
| mem_din | input | 16 | Read data from memory |

## Verification
A phase counter that reloads wrongly or skips a phase shows up within the same access. The run of address-valid, chip-select and strobe clocks comes out too long, too short or out of order, and the ack arrives a clock early or late. A wrong byte-lane decision shows up in the strobe clock itself, as the wrong write-strobe bits or the wrong data lane, and then in `rd_data` once ack is seen. A float-gap count that is off shows up only at the start of the following access, as a changed distance from ack to the next address-valid rise.

// File: rtl/smc_bank_timer.sv
module smc_bank_timer #(
  parameter int ADDR_W = 16,
  parameter int NWS_W  = 7,
  parameter int TDF_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_addr_gap,
  input  logic [1:0]        cfg_cs_setup,
  input  logic [1:0]        cfg_cs_hold,
  input  logic              cfg_wait_en,
  input  logic [NWS_W-1:0]  cfg_wait,
  input  logic [TDF_W-1:0]  cfg_float,
  input  logic              cfg_early_rd,
  input  logic              cfg_bus16,
  input  logic              cfg_dual8,
  input  logic              req,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              ack,
  output logic [15:0]       rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_addr_vld,
  output logic              mem_cs_n,
  output logic              mem_rd_n,
  output logic [1:0]        mem_we_n,
  output logic [15:0]       mem_dout,
  output logic              mem_doe,
  input  logic [15:0]       mem_din
);

  localparam int CNT_W = (NWS_W + 1 > TDF_W) ? NWS_W + 1 : TDF_W;

  typedef enum logic [2:0] {
    P_ASU = 3'd0, P_CSU = 3'd1, P_STB = 3'd2, P_CSH = 3'd3,
    P_AH  = 3'd4, P_ACK = 3'd5, P_IDLE = 3'd6, P_FLT = 3'd7
  } ph_t;

  ph_t               ph, hop;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  len [0:7];
  logic              wr_q, wide_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       wdata_q;
  logic [1:0]        lane_en;
  logic [15:0]       rd_pick;
  logic              cs_on;
  int                from_i;

  always_comb begin
    len[0] = CNT_W'(cfg_addr_gap);
    len[1] = CNT_W'(cfg_cs_setup);
    len[2] = cfg_wait_en ? CNT_W'(cfg_wait) + 1'b1 : CNT_W'(1);
    len[3] = CNT_W'(cfg_cs_hold);
    len[4] = CNT_W'(cfg_addr_gap);
    len[5] = CNT_W'(1);
    len[6] = '0;
    len[7] = '0;
  end

  always_comb begin
    from_i = (ph == P_IDLE) ? 0 : int'(ph) + 1;
    hop = P_ACK;
    for (int k = 4; k >= 0; k--)
      if (k >= from_i && len[k] != '0) hop = ph_t'(3'(k));
  end

  assign lane_en = !cfg_bus16                ? 2'b01 :
                   (wide_q || !cfg_dual8)    ? 2'b11 :
                   addr_q[0]                 ? 2'b10 : 2'b01;

  assign rd_pick = !cfg_bus16 ? {8'h00, mem_din[7:0]} :
                   wide_q     ? mem_din :
                   {8'h00, addr_q[0] ? mem_din[15:8] : mem_din[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= P_IDLE;
      cnt     <= '0;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_data <= '0;
    end else begin
      case (ph)
        P_IDLE: if (req) begin
          wr_q    <= req_write;
          wide_q  <= req_wide;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          ph      <= hop;
          cnt     <= len[hop] - 1'b1;
        end
        P_ACK: begin
          if (!wr_q && cfg_float != '0) begin
            ph  <= P_FLT;
            cnt <= CNT_W'(cfg_float) - 1'b1;
          end else begin
            ph <= P_IDLE;
          end
        end
        P_FLT: begin
          if (cnt == '0) ph <= P_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: begin
          if (ph == P_STB && cnt == '0 && !wr_q) rd_data <= rd_pick;
          if (cnt == '0) begin
            ph  <= hop;
            cnt <= len[hop] - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assign cs_on        = (ph == P_CSU) || (ph == P_STB) || (ph == P_CSH);
  assign mem_addr_vld = (ph == P_ASU) || cs_on || (ph == P_AH);
  assign mem_cs_n     = !cs_on;
  assign mem_rd_n     = !(!wr_q && ((ph == P_STB) || (cfg_early_rd && ph == P_CSU)));
  assign mem_we_n     = (wr_q && ph == P_STB) ? ~lane_en : 2'b11;
  assign mem_doe      = wr_q && cs_on;
  assign mem_dout     = (cfg_bus16 && wide_q) ? wdata_q : {2{wdata_q[7:0]}};
  assign mem_addr     = addr_q;
  assign ack          = (ph == P_ACK);

  assert_cs_inside_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> mem_addr_vld);

  assert_strobe_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || mem_we_n != 2'b11) |-> !mem_cs_n);

  assert_early_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_cs_n) && cfg_early_rd && !wr_q) |-> !mem_rd_n);

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_write_driven_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n != 2'b11) |-> (mem_doe && mem_rd_n));

  assert_float_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr_q && cfg_float != '0) |=> (mem_cs_n && !mem_addr_vld));

endmodule

// File: tb/sim_smc_bank_timer.sv
`timescale 1ns/1ps
module sim_smc_bank_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]  c_gap = 0, c_csu = 0, c_csh = 0;
  logic        c_wen = 0, c_early = 0, c_b16 = 1, c_dual = 0;
  logic [6:0]  c_wait = 0;
  logic [3:0]  c_flt = 0;
  logic        req = 0, req_write = 0, req_wide = 0;
  logic [15:0] req_addr = 0, req_wdata = 0;
  logic        ack, m_vld, m_cs_n, m_rd_n, m_doe;
  logic [15:0] rd_data, m_addr, m_dout;
  logic [1:0]  m_we_n;
  logic [15:0] mem_din = 16'hA5A5, din_base = 0;
  int          sidx = 0;

  smc_bank_timer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_addr_gap(c_gap), .cfg_cs_setup(c_csu),
    .cfg_cs_hold(c_csh), .cfg_wait_en(c_wen), .cfg_wait(c_wait), .cfg_float(c_flt),
    .cfg_early_rd(c_early), .cfg_bus16(c_b16), .cfg_dual8(c_dual),
    .req(req), .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rd_data(rd_data), .mem_addr(m_addr),
    .mem_addr_vld(m_vld), .mem_cs_n(m_cs_n), .mem_rd_n(m_rd_n), .mem_we_n(m_we_n),
    .mem_dout(m_dout), .mem_doe(m_doe), .mem_din(mem_din));

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!m_rd_n) begin mem_din <= din_base + 16'(sidx); sidx <= sidx + 1; end
    else begin mem_din <= 16'hA5A5; sidx <= 0; end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  logic [2:0]  trace [0:159];
  int          tr_len, ack_cyc, vld_cyc;
  logic [1:0]  s_we;
  logic [15:0] s_dout, s_addr;
  logic        s_doe;

  task automatic xfer(input bit we, input bit wide, input logic [15:0] addr,
                      input logic [15:0] wd, input bit hold);
    bit started = 0, done = 0, strb;
    int guard = 0;
    req = 1; req_write = we; req_wide = wide; req_addr = addr; req_wdata = wd;
    tr_len = 0; vld_cyc = -1;
    while (!done) begin
      @(negedge clk);
      guard++;
      strb = !m_rd_n || (m_we_n != 2'b11);
      if (ack) begin
        ack_cyc = cyc; done = 1;
      end else if (guard > 400) begin
        chk(0, "R7 ack never seen", 0, 1); done = 1;
      end else if (started || m_vld || !m_cs_n) begin
        if (!started) vld_cyc = cyc;
        started = 1;
        if (tr_len < 160) trace[tr_len] = {m_vld, !m_cs_n, strb};
        tr_len++;
        if (m_we_n != 2'b11) begin
          s_we = m_we_n; s_dout = m_dout; s_addr = m_addr; s_doe = m_doe;
        end
      end
    end
    if (!hold) req = 0;
  endtask

  task automatic check_trace(input int a, input int s, input int h, input int n, input bit er);
    logic [2:0] ex [0:159];
    int e = 0, act, expv;
    bit ok;
    for (int i = 0; i < a; i++) begin ex[e] = 3'b100; e++; end
    for (int i = 0; i < s; i++) begin ex[e] = {2'b11, er}; e++; end
    for (int i = 0; i < n; i++) begin ex[e] = 3'b111; e++; end
    for (int i = 0; i < h; i++) begin ex[e] = 3'b110; e++; end
    for (int i = 0; i < a; i++) begin ex[e] = 3'b100; e++; end
    ok = (e == tr_len); act = tr_len; expv = e;
    if (ok)
      for (int i = 0; i < e; i++)
        if (ok && trace[i] != ex[i]) begin ok = 0; act = 100 + int'(trace[i]); expv = 100 + int'(ex[i]); end
    chk(ok, "R2 R3 R4 R5 R6 phase trace (len or 100+code)", act, expv);
  endtask

  initial begin
    #(5.0 * 190000);
    chk(0, "watchdog expired", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, cnt = 0;
    logic [15:0] expd;
    logic [1:0]  expw;
    repeat (3) @(negedge clk);
    chk(m_cs_n && m_rd_n && m_we_n == 2'b11 && !ack && !m_vld && !m_doe,
        "R1 outputs in reset", 0, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(m_cs_n && m_rd_n && m_we_n == 2'b11 && !ack && !m_vld && !m_doe,
        "R1 outputs idle after reset", 0, 1);

    // timing sweep on a 16-bit bus, 16-bit accesses
    for (int a = 0; a < 4; a++)
      for (int s = 0; s < 4; s++)
        for (int h = 0; h < 4; h++)
          for (int w = 0; w < 4; w++)
            for (int er = 0; er < 2; er++)
              for (int we = 0; we < 2; we++) begin
                c_gap = 2'(a); c_csu = 2'(s); c_csh = 2'(h); c_early = er[0];
                c_wen = (w != 0);
                c_wait = (w == 0) ? 7'd9 : (w == 1) ? 7'd0 : (w == 2) ? 7'd2 : 7'd5;
                n = (w == 0) ? 1 : int'(c_wait) + 1;
                cnt++; din_base = 16'(16'h1000 + cnt * 7);
                xfer(we[0], 1'b1, 16'(cnt * 2), 16'(cnt), 1'b0);
                check_trace(a, s, h, n, er[0] && !we[0]);
                if (we == 0) begin
                  expd = din_base + 16'((er != 0 ? s : 0) + n - 1);
                  chk(rd_data == expd, "R8 data from last strobe clock", rd_data, expd);
                end
                @(negedge clk);
                chk(!ack && m_cs_n, "R7 ack lasts one clock", ack, 0);
              end

    // longest and ignored wait counts
    c_gap = 1; c_csu = 1; c_csh = 1; c_early = 0; c_wen = 1; c_wait = 7'd127;
    din_base = 16'h2000;
    xfer(1'b0, 1'b1, 16'h0010, 16'h0, 1'b0);
    check_trace(1, 1, 1, 128, 1'b0);
    chk(rd_data == 16'h207F, "R4 R8 128-clock strobe capture", rd_data, 16'h207F);
    c_wen = 0;
    xfer(1'b1, 1'b1, 16'h0012, 16'h1234, 1'b0);
    check_trace(1, 1, 1, 1, 1'b0);
    chk(1, "R4 wait count ignored when disabled", 0, 0);

    // byte lanes
    c_gap = 0; c_csu = 0; c_csh = 0; c_wen = 0;
    for (int b = 0; b < 2; b++)
      for (int d = 0; d < 2; d++)
        for (int wd = 0; wd < 2; wd++)
          for (int l = 0; l < 2; l++)
            for (int we = 0; we < 2; we++) begin
              c_b16 = b[0]; c_dual = d[0];
              din_base = 16'(16'hC3B0 + b * 8 + d * 4 + wd * 2 + l);
              xfer(we[0], wd[0], 16'(16'h0100 + l), 16'hBE5A, 1'b0);
              if (we == 1) begin
                expw = (b == 0) ? 2'b10 : (wd == 1 || d == 0) ? 2'b00 : (l == 1) ? 2'b01 : 2'b10;
                expd = (b == 1 && wd == 1) ? 16'hBE5A : 16'h5A5A;
                chk(s_we == expw, "R9 R11 write strobe lanes", s_we, expw);
                chk(s_dout == expd && s_doe, "R9 write data and drive", s_dout, expd);
                chk(s_addr == 16'(16'h0100 + l), "R9 address during strobe", s_addr, 16'h0100 + l);
              end else begin
                expd = (b == 0) ? {8'h00, din_base[7:0]} : (wd == 1) ? din_base :
                       {8'h00, (l == 1) ? din_base[15:8] : din_base[7:0]};
                chk(rd_data == expd, "R8 R11 read lane select", rd_data, expd);
              end
            end

    // float gap between back-to-back accesses
    c_b16 = 1; c_dual = 0; c_gap = 1; c_csu = 1; c_csh = 1;
    for (int t = 0; t < 16; t++)
      for (int we = 0; we < 2; we++) begin
        int first_ack;
        c_flt = 4'(t);
        xfer(we[0], 1'b1, 16'h0040, 16'h0, 1'b1);
        first_ack = ack_cyc;
        xfer(1'b0, 1'b1, 16'h0042, 16'h0, 1'b0);
        chk(vld_cyc - first_ack == ((we == 0) ? t + 2 : 2), "R10 R7 gap after ack",
            vld_cyc - first_ack, (we == 0) ? t + 2 : 2);
      end

    repeat (20) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule